// File: doc/BRIEF.md
# Two-Step Software Reset Sequencer

This block sits behind the serial command port of a flash-style device. It watches the single-bit SPI lines (mode 0: data sampled on the rising clock edge, most significant bit first) and rebuilds each complete 8-bit instruction. It then looks for a valid reset sequence: an arming instruction, followed directly by an execute instruction. When it sees that sequence, it sends a one-cycle reset pulse to the rest of the device. The pulse aborts any internal operation, even one that is flagged busy, and returns every volatile register to its power-on value. This covers the result register, which goes to 00h, and the session keys, which become invalid.

The reset can arrive at any time, so the sequencer never waits for the other blocks. As the pulse fires, it raises a lockout flag for a fixed number of system-clock cycles. The command decoder refuses instructions while the flag is high, and the sequencer ignores them too. A frame counts as an instruction only when chip select rises after exactly eight clock edges. Frames of any other length leave the sequencer unchanged. The SPI inputs are asynchronous to the system clock and pass through a synchronizer inside the block.

Top module: `swrst_seq`

## Requirements
- R1: A frame counts as an instruction only when spi_cs_n rises after exactly INSTR_BITS rising edges of spi_sclk. Bits are taken on the rising spi_sclk edges, first bit is the most significant.
- R2: An instruction equal to ARM_CODE (default 66h) puts the sequencer in the armed state.
- R3: An EXEC_CODE instruction (default 99h) received while armed produces a reset_pulse exactly one cycle wide and leaves the sequencer disarmed.
- R4: An EXEC_CODE instruction received while not armed produces no reset_pulse.
- R5: Any complete instruction other than ARM_CODE or EXEC_CODE received while armed disarms the sequencer. A later EXEC_CODE then has no effect.
- R6: A frame with fewer or more than INSTR_BITS clock edges neither arms nor disarms the sequencer.
- R7: lockout rises in the same cycle as reset_pulse and stays high for exactly LOCK_CYCLES cycles.
- R8: Instructions that complete while lockout is high are ignored. This includes ARM_CODE and EXEC_CODE, and after lockout ends the sequencer is disarmed.
- R9: After rst_n is released, reset_pulse and lockout are low and the sequencer is disarmed.
- R10: A repeated ARM_CODE while armed keeps the sequencer armed, so a following EXEC_CODE still produces the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| spi_sclk | input | 1 | Serial clock from the host, asynchronous |
| spi_cs_n | input | 1 | Active-low chip select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| reset_pulse | output | 1 | One-cycle pulse that clears volatile state and aborts operations |
| lockout | output | 1 | High while new instructions must be refused |

## Verification
The bench sets LOCK_CYCLES to 400. That is short enough to wait out after every reset within the run. It is also long enough that two whole instruction frames fit inside one lockout window, so the bench can check that arming and executing are both ignored during lockout. The instruction width and codes stay at their defaults. Random frame streams mix the arm and execute codes with other bytes and with 7- and 9-bit frames. This reaches the disarm, re-arm and length-filter orderings against a bench model of the armed state.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
    typedef enum logic {
        ARM_IDLE  = 1'b0,
        ARM_READY = 1'b1
    } arm_state_e;
endpackage

// File: rtl/swrst_byte_rx.sv
module swrst_byte_rx #(
    parameter int INSTR_BITS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_i,
    input  logic                  cs_n_i,
    input  logic                  mosi_i,
    output logic                  vld_o,
    output logic [INSTR_BITS-1:0] byte_o
);
    localparam int CW = $clog2(INSTR_BITS + 2);
    localparam logic [CW-1:0] FULL = CW'(INSTR_BITS);
    localparam logic [CW-1:0] OVER = CW'(INSTR_BITS + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] cs_p;
        logic [SYNC_STAGES-1:0] ck_p;
        logic [SYNC_STAGES-1:0] di_p;
        logic                   ck_old;
        logic                   cs_old;
        logic [INSTR_BITS-1:0]  sh;
        logic [CW-1:0]          cnt;
        logic                   vld;
    } rx_t;

    rx_t rx_d, rx_q;
    logic cs_s, ck_s, di_s;

    assign cs_s = rx_q.cs_p[SYNC_STAGES-1];
    assign ck_s = rx_q.ck_p[SYNC_STAGES-1];
    assign di_s = rx_q.di_p[SYNC_STAGES-1];

    always_comb begin
        rx_d        = rx_q;
        rx_d.cs_p   = {rx_q.cs_p[SYNC_STAGES-2:0], cs_n_i};
        rx_d.ck_p   = {rx_q.ck_p[SYNC_STAGES-2:0], sclk_i};
        rx_d.di_p   = {rx_q.di_p[SYNC_STAGES-2:0], mosi_i};
        rx_d.ck_old = ck_s;
        rx_d.cs_old = cs_s;
        rx_d.vld    = 1'b0;
        if (cs_s) begin
            if (!rx_q.cs_old && rx_q.cnt == FULL) begin
                rx_d.vld = 1'b1;
            end
            rx_d.cnt = '0;
        end else if (ck_s && !rx_q.ck_old) begin
            rx_d.sh = {rx_q.sh[INSTR_BITS-2:0], di_s};
            if (rx_q.cnt != OVER) begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q        <= '0;
            rx_q.cs_p   <= '1;
            rx_q.cs_old <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign vld_o  = rx_q.vld;
    assign byte_o = rx_q.sh;

    assert_vld_after_cs_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.vld |-> $past(cs_s) && !$past(rx_q.cs_old));
    assert_cnt_saturates_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.cnt <= OVER);
    assert_vld_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.vld |=> !rx_q.vld);
endmodule

// File: rtl/swrst_arm_ctl.sv
module swrst_arm_ctl
    import swrst_pkg::*;
#(
    parameter int                  INSTR_BITS = 8,
    parameter logic [INSTR_BITS-1:0] ARM_CODE  = 8'h66,
    parameter logic [INSTR_BITS-1:0] EXEC_CODE = 8'h99
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vld_i,
    input  logic [INSTR_BITS-1:0] byte_i,
    input  logic                  lock_i,
    output logic                  fire_o,
    output logic                  pulse_o
);
    typedef struct packed {
        arm_state_e st;
        logic       pulse;
    } arm_t;

    arm_t arm_d, arm_q;

    always_comb begin
        arm_d       = arm_q;
        arm_d.pulse = 1'b0;
        fire_o      = 1'b0;
        if (lock_i) begin
            arm_d.st = ARM_IDLE;
        end else if (vld_i) begin
            if (byte_i == ARM_CODE) begin
                arm_d.st = ARM_READY;
            end else if (byte_i == EXEC_CODE && arm_q.st == ARM_READY) begin
                fire_o      = 1'b1;
                arm_d.pulse = 1'b1;
                arm_d.st    = ARM_IDLE;
            end else begin
                arm_d.st = ARM_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= '{st: ARM_IDLE, pulse: 1'b0};
        end else begin
            arm_q <= arm_d;
        end
    end

    assign pulse_o = arm_q.pulse;

    assert_pulse_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q.pulse |=> !arm_q.pulse);
    assert_pulse_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q.pulse |-> $past(arm_q.st) == ARM_READY);
    assert_disarmed_in_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |-> arm_q.st == ARM_IDLE);
    assert_pulse_after_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q.pulse |-> $past(vld_i) && $past(byte_i) == EXEC_CODE);
endmodule

// File: rtl/swrst_lock_tmr.sv
module swrst_lock_tmr #(
    parameter int LOCK_CYCLES = 3750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic lock_o
);
    localparam int LW = $clog2(LOCK_CYCLES + 1);
    localparam logic [LW-1:0] LOAD_VAL = LW'(LOCK_CYCLES);

    typedef struct packed {
        logic [LW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = LOAD_VAL;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign lock_o = (tmr_q.cnt != '0);

    assert_cnt_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LOAD_VAL);
    assert_lock_rise_from_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o && !$past(lock_o) |-> $past(load_i));
endmodule

// File: rtl/swrst_seq.sv
module swrst_seq #(
    parameter int                    INSTR_BITS  = 8,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [INSTR_BITS-1:0] ARM_CODE    = 8'h66,
    parameter logic [INSTR_BITS-1:0] EXEC_CODE   = 8'h99,
    parameter int                    LOCK_CYCLES = 3750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic reset_pulse,
    output logic lockout
);
    logic                  rx_vld;
    logic [INSTR_BITS-1:0] rx_byte;
    logic                  fire;

    swrst_byte_rx #(.INSTR_BITS(INSTR_BITS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n),
        .mosi_i(spi_mosi), .vld_o(rx_vld), .byte_o(rx_byte)
    );

    swrst_arm_ctl #(.INSTR_BITS(INSTR_BITS), .ARM_CODE(ARM_CODE), .EXEC_CODE(EXEC_CODE)) u_arm (
        .clk(clk), .rst_n(rst_n), .vld_i(rx_vld), .byte_i(rx_byte),
        .lock_i(lockout), .fire_o(fire), .pulse_o(reset_pulse)
    );

    swrst_lock_tmr #(.LOCK_CYCLES(LOCK_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load_i(fire), .lock_o(lockout)
    );

    assert_pulse_with_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> lockout);
    assert_no_pulse_from_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> !$past(lockout));
endmodule

// File: tb/swrst_seq_test.sv
module swrst_seq_test;
    localparam int LOCK = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic reset_pulse, lockout;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    int run = 0;
    int last_len = 0;
    bit armed_m = 1'b0;

    always #4 clk = ~clk;

    swrst_seq #(.LOCK_CYCLES(LOCK)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .reset_pulse(reset_pulse), .lockout(lockout)
    );

    always @(negedge clk) begin
        if (reset_pulse) pulses++;
        if (lockout) run++;
        else if (run != 0) begin
            last_len = run;
            run = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] data, input int nb);
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = nb - 1; i >= 0; i--) begin
            mosi = data[i];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    // model of the armed state; returns 1 when a reset is expected
    function automatic bit model(input logic [7:0] b, input int nb);
        bit f = 1'b0;
        if (nb != 8) return 1'b0;
        if (b == 8'h66) armed_m = 1'b1;
        else if (b == 8'h99 && armed_m) begin f = 1'b1; armed_m = 1'b0; end
        else armed_m = 1'b0;
        return f;
    endfunction

    task automatic wait_unlock();
        while (lockout) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic frame_chk(input logic [15:0] d, input int nb, input string tag);
        int p0 = pulses;
        bit e = model(d[7:0], nb);
        send(d, nb);
        chk((pulses - p0) == int'(e), tag, pulses - p0, int'(e));
        if (e) begin
            wait_unlock();
            chk(last_len == LOCK, "R7 lockout length", last_len, LOCK);
        end
    endtask

    initial begin
        repeat (2000000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        chk(reset_pulse == 1'b0, "R9 pulse in reset", reset_pulse, 0);
        chk(lockout == 1'b0, "R9 lockout in reset", lockout, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(reset_pulse == 1'b0 && lockout == 1'b0, "R9 idle after reset", lockout, 0);

        // R4: execute alone, straight after reset (disarmed)
        frame_chk(16'h99, 8, "R4 exec without arm");
        // R2 R3: arm then execute
        frame_chk(16'h66, 8, "R2 arm");
        frame_chk(16'h99, 8, "R3 exec after arm");
        // R5: intervening instruction disarms
        frame_chk(16'h66, 8, "R5 arm");
        frame_chk(16'hA5, 8, "R5 other instr");
        frame_chk(16'h99, 8, "R5 exec after disarm");
        // R6 R1: 9-bit and 7-bit frames ignored
        frame_chk(16'h66, 8, "R6 arm");
        frame_chk(16'h133, 9, "R6 nine-bit frame");
        frame_chk(16'h4C, 7, "R6 seven-bit frame");
        frame_chk(16'h99, 8, "R6 exec still armed");
        // R1: a 9-bit frame whose last 8 bits are the execute code is not one
        frame_chk(16'h66, 8, "R1 arm");
        frame_chk(16'h099, 9, "R1 nine-bit exec rejected");
        frame_chk(16'h99, 8, "R1 exec still armed");
        // R10: repeated arm
        frame_chk(16'h66, 8, "R10 arm");
        frame_chk(16'h66, 8, "R10 arm again");
        frame_chk(16'h99, 8, "R10 exec");

        // R8: arm and execute during lockout are ignored
        begin
            int p0;
            send(16'h66, 8);
            send(16'h99, 8);
            p0 = pulses;
            chk(lockout == 1'b1, "R8 lockout active", lockout, 1);
            send(16'h66, 8);
            send(16'h99, 8);
            chk(lockout == 1'b1, "R8 still in lockout", lockout, 1);
            chk(pulses == p0, "R8 pair in lockout", pulses - p0, 0);
            wait_unlock();
            send(16'h99, 8);
            chk(pulses == p0, "R8 disarmed after lockout", pulses - p0, 0);
            armed_m = 1'b0;
        end

        // random mix
        for (int k = 0; k < 80; k++) begin
            int sel = $urandom_range(0, 9);
            logic [15:0] d;
            int nb = 8;
            if (sel < 4) d = 16'h66;
            else if (sel < 7) d = 16'h99;
            else if (sel < 9) d = 16'($urandom_range(0, 255));
            else begin
                nb = ($urandom_range(0, 1) == 0) ? 7 : 9;
                d = 16'($urandom_range(0, 511));
            end
            frame_chk(d, nb, "R5 random stream");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule